// File: doc/BRIEF.md
# Privilege-Mode Banked Register File

This block holds the sixteen 32-bit general registers of a processor core that runs in several privilege modes. Software sees one flat set of sixteen registers through two combinational read ports and one synchronous write port. Some of those registers have shadow copies. When a mode-change request moves the core into a mode that owns a different shadow bank, the live values go to the outgoing bank and the incoming bank's values replace them, all on one clock edge. The block also keeps one live saved-status word and one shadow copy of it per bank. That word is swapped together with the registers.

Stack pointer (r13) and link register (r14) have a shadow copy in every exceptional mode. The fast-interrupt mode also shadows r8 to r12. All other modes share a single copy of those five registers. User and system modes share the unbanked set. Any mode encoding that is not recognised also uses the unbanked set. The current mode is held in a register and driven out, so the surrounding decode and exception logic can use it.

Top module: `bankreg_top`

## Requirements
- R1: While reset (rst_n low) is held and after it is released, all sixteen live registers, every shadow copy and the saved-status word read as zero, and curMode reads 5'h1F (system).
- R2: A write with wrEn high updates register wrAddr at the clock edge. Both read ports then return the new value combinationally for any register they address.
- R3: A mode request whose target equals curMode changes no register, no saved-status value and not curMode.
- R4: A move between user (5'h10) and system (5'h1F) swaps nothing. Every register and the saved status keep their live values.
- R5: Bank selection by encoding: 5'h11 fast-interrupt, 5'h12 interrupt, 5'h13 supervisor, 5'h17 abort and 5'h1B undefined each own a bank. 5'h10, 5'h1F and every other encoding use the unbanked set.
- R6: On a change of bank, live r13 and r14 are stored into the outgoing bank's shadow and loaded from the incoming bank's shadow. Each bank's values therefore survive any round trip.
- R7: r8 to r12 are swapped only when the old or the new mode is fast-interrupt. Their storage is two sets: one for fast-interrupt and one shared by all other modes.
- R8: On a change of bank, the saved-status word is stored into the outgoing bank's slot and reloaded from the incoming bank's slot.
- R9: A register write or a saved-status write in the same cycle as a mode change lands in the live copy after the change, that is, in the incoming bank.
- R10: Following any mode request, curMode equals the requested 5-bit target, including unrecognised encodings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rdAddrA | input | 4 | Read port A register index |
| rdDataA | output | 32 | Read port A data (combinational) |
| rdAddrB | input | 4 | Read port B register index |
| rdDataB | output | 32 | Read port B data (combinational) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write index |
| wrData | input | 32 | Register write data |
| ssrWrEn | input | 1 | Saved-status write strobe |
| ssrWrData | input | 32 | Saved-status write data |
| ssrRdData | output | 32 | Live saved-status word |
| modeReq | input | 1 | Mode-change request strobe |
| modeTarget | input | 5 | Requested mode encoding |
| curMode | output | 5 | Current mode encoding |

## Verification
The hold properties for a same-mode request and for a user/system move only claim stability when no register or saved-status write occurs in that cycle. The write-visibility property assumes that read port A keeps its address from the write cycle to the next. The bench therefore issues mode requests with the write strobes low, except in the dedicated same-cycle write test. It changes read addresses only between checks.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int MODE_W = 5;

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

  typedef enum logic [2:0] {
    BANK_NONE = 3'd0,
    BANK_FIQ  = 3'd1,
    BANK_IRQ  = 3'd2,
    BANK_SVC  = 3'd3,
    BANK_ABT  = 3'd4,
    BANK_UND  = 3'd5
  } bank_t;

  localparam int NUM_BANKS = 6;

  // Strobes from control to datapath, valid for one edge
  typedef struct packed {
    logic  swap;       // r13/r14/saved-status change bank
    logic  fiqSwap;    // r8..r12 change set
    bank_t oldBank;
    bank_t newBank;
    logic  oldHiSet;   // 1 = fast-interrupt set
    logic  newHiSet;
  } ctrl_strobe_t;

  function automatic bank_t bankOf(logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return BANK_FIQ;
      MODE_IRQ: return BANK_IRQ;
      MODE_SVC: return BANK_SVC;
      MODE_ABT: return BANK_ABT;
      MODE_UND: return BANK_UND;
      default:  return BANK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/bankreg_ctrl.sv
module bankreg_ctrl
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeReq,
  input  logic [MODE_W-1:0] modeTarget,
  output logic [MODE_W-1:0] curMode,
  output ctrl_strobe_t      strb
);

  logic [MODE_W-1:0] modeQ;
  logic              changeReq;
  bank_t             curBank;
  bank_t             tgtBank;

  assign changeReq = modeReq && (modeTarget != modeQ);
  assign curBank   = bankOf(modeQ);
  assign tgtBank   = bankOf(modeTarget);

  always_comb begin
    strb          = '0;
    strb.oldBank  = curBank;
    strb.newBank  = tgtBank;
    strb.oldHiSet = (curBank == BANK_FIQ);
    strb.newHiSet = (tgtBank == BANK_FIQ);
    if (changeReq && (curBank != tgtBank)) begin
      strb.swap    = 1'b1;
      strb.fiqSwap = (curBank == BANK_FIQ) || (tgtBank == BANK_FIQ);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         modeQ <= MODE_SYS;
    else if (changeReq) modeQ <= modeTarget;
  end

  assign curMode = modeQ;

endmodule

// File: rtl/bankreg_dp.sv
module bankreg_dp
  import bankreg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int SP_IDX   = 13,
  parameter int LR_IDX   = 14,
  parameter int HI_BASE  = 8,
  parameter int HI_CNT   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctrl_strobe_t                strb,
  input  logic [$clog2(NUM_REGS)-1:0] rdAddrA,
  output logic [DATA_W-1:0]           rdDataA,
  input  logic [$clog2(NUM_REGS)-1:0] rdAddrB,
  output logic [DATA_W-1:0]           rdDataB,
  input  logic                        wrEn,
  input  logic [$clog2(NUM_REGS)-1:0] wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic                        ssrWrEn,
  input  logic [DATA_W-1:0]           ssrWrData,
  output logic [DATA_W-1:0]           ssrRdData
);

  localparam int ADDR_W = $clog2(NUM_REGS);
  localparam int HI_TOP = HI_BASE + HI_CNT;

  logic [NUM_REGS-1:0][DATA_W-1:0] liveFlat;
  logic [DATA_W-1:0] shadowSp  [NUM_BANKS];
  logic [DATA_W-1:0] shadowLr  [NUM_BANKS];
  logic [DATA_W-1:0] shadowSsr [NUM_BANKS];
  logic [DATA_W-1:0] hiSet     [2][HI_CNT];
  logic [DATA_W-1:0] liveSsr;

  // Live registers: each picks its swap source by role
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_live
    logic              swapIn;
    logic [DATA_W-1:0] swapVal;
    logic [DATA_W-1:0] q;

    if (g == SP_IDX) begin : g_sp
      assign swapIn  = strb.swap;
      assign swapVal = shadowSp[strb.newBank];
    end else if (g == LR_IDX) begin : g_lr
      assign swapIn  = strb.swap;
      assign swapVal = shadowLr[strb.newBank];
    end else if (g >= HI_BASE && g < HI_TOP) begin : g_hi
      assign swapIn  = strb.fiqSwap;
      assign swapVal = hiSet[strb.newHiSet][g-HI_BASE];
    end else begin : g_flat
      assign swapIn  = 1'b0;
      assign swapVal = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= '0;
      else if (wrEn && wrAddr == ADDR_W'(g))  q <= wrData;
      else if (swapIn)                        q <= swapVal;
    end

    assign liveFlat[g] = q;
  end

  // Outgoing SP/LR/status into the old bank's slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        shadowSp[b]  <= '0;
        shadowLr[b]  <= '0;
        shadowSsr[b] <= '0;
      end
    end else if (strb.swap) begin
      shadowSp[strb.oldBank]  <= liveFlat[SP_IDX];
      shadowLr[strb.oldBank]  <= liveFlat[LR_IDX];
      shadowSsr[strb.oldBank] <= liveSsr;
    end
  end

  // Two-set storage for r8..r12
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < HI_CNT; k++)
          hiSet[s][k] <= '0;
    end else if (strb.fiqSwap) begin
      for (int k = 0; k < HI_CNT; k++)
        hiSet[strb.oldHiSet][k] <= liveFlat[HI_BASE+k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          liveSsr <= '0;
    else if (ssrWrEn)    liveSsr <= ssrWrData;
    else if (strb.swap)  liveSsr <= shadowSsr[strb.newBank];
  end

  assign rdDataA   = liveFlat[rdAddrA];
  assign rdDataB   = liveFlat[rdAddrB];
  assign ssrRdData = liveSsr;

endmodule

// File: rtl/bankreg_top.sv
module bankreg_top
  import bankreg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ssrWrEn,
  input  logic [DATA_W-1:0] ssrWrData,
  output logic [DATA_W-1:0] ssrRdData,
  input  logic              modeReq,
  input  logic [MODE_W-1:0] modeTarget,
  output logic [MODE_W-1:0] curMode
);

  ctrl_strobe_t strb;

  bankreg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .modeReq    (modeReq),
    .modeTarget (modeTarget),
    .curMode    (curMode),
    .strb       (strb)
  );

  bankreg_dp #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .rdAddrA   (rdAddrA),
    .rdDataA   (rdDataA),
    .rdAddrB   (rdAddrB),
    .rdDataB   (rdDataB),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .ssrWrEn   (ssrWrEn),
    .ssrWrData (ssrWrData),
    .ssrRdData (ssrRdData)
  );

endmodule

// File: rtl/bankreg_chk.sv
module bankreg_chk
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              ssrWrEn,
  input logic [DATA_W-1:0] ssrRdData,
  input logic              modeReq,
  input logic [MODE_W-1:0] modeTarget,
  input logic [MODE_W-1:0] curMode
);

  // R1
  reset_mode_chk: assert property (@(posedge clk)
    !rst_n |=> (curMode == MODE_SYS && ssrRdData == '0));

  // R10
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modeReq |=> curMode == $past(modeTarget));

  // R2
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> (rdAddrA != $past(wrAddr) || rdDataA == $past(wrData)));

  // R3
  same_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeReq && modeTarget == curMode && !wrEn && !ssrWrEn) |=>
      ($stable(ssrRdData) && $stable(curMode) &&
       (rdAddrA != $past(rdAddrA) || $stable(rdDataA))));

  // R4
  usr_sys_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeReq && !wrEn && !ssrWrEn &&
     ((curMode == MODE_USR && modeTarget == MODE_SYS) ||
      (curMode == MODE_SYS && modeTarget == MODE_USR))) |=>
      ($stable(ssrRdData) && (rdAddrA != $past(rdAddrA) || $stable(rdDataA))));

endmodule

bind bankreg_top bankreg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rdAddrA    (rdAddrA),
  .rdDataA    (rdDataA),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .ssrWrEn    (ssrWrEn),
  .ssrRdData  (ssrRdData),
  .modeReq    (modeReq),
  .modeTarget (modeTarget),
  .curMode    (curMode)
);

// File: tb/bankreg_top_tb.sv
module bankreg_top_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0, ssrWrData = '0, ssrRdData;
  logic        wrEn = 1'b0, ssrWrEn = 1'b0, modeReq = 1'b0;
  logic [4:0]  modeTarget = '0, curMode;

  int checks = 0;
  int fails  = 0;
  bit written [6];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bankreg_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ssrWrEn(ssrWrEn), .ssrWrData(ssrWrData), .ssrRdData(ssrRdData),
    .modeReq(modeReq), .modeTarget(modeTarget), .curMode(curMode)
  );

  // Bank index per R5: 0 none, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und
  function automatic int bankIdx(logic [4:0] m);
    case (m)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] pat(int b, int i);
    return 32'hC0DE_0000 | (b << 8) | i;
  endfunction

  function automatic logic [31:0] ssrPat(int b);
    return 32'h5A5A_0000 | b;
  endfunction

  // Expected live value of register i while bank b is selected
  function automatic logic [31:0] expReg(int b, int i);
    if (i == 13 || i == 14) return written[b] ? pat(b, i) : 32'h0;
    if (i >= 8 && i <= 12 && b == 1) return written[1] ? pat(1, i) : 32'h0;
    return written[0] ? pat(0, i) : 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAll(int b, string req);
    for (int i = 0; i < 16; i++) begin
      rdAddrA = 4'(i);
      rdAddrB = 4'(15 - i);
      #1;
      check(req, rdDataA, expReg(b, i));
      check(req, rdDataB, expReg(b, 15 - i));
    end
    check(req, ssrRdData, written[b] ? ssrPat(b) : 32'h0);
  endtask

  task automatic writeReg(int i, logic [31:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(i); wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeSsr(logic [31:0] v);
    @(negedge clk);
    ssrWrEn = 1'b1; ssrWrData = v;
    @(negedge clk);
    ssrWrEn = 1'b0;
  endtask

  task automatic changeMode(logic [4:0] m, string req);
    @(negedge clk);
    modeReq = 1'b1; modeTarget = m;
    @(negedge clk);
    modeReq = 1'b0;
    #1;
    check(req, 32'(curMode), 32'(m));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [4:0] fwd [5];
    logic [4:0] back [9];
    fwd  = '{5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};
    back = '{5'h13, 5'h11, 5'h1B, 5'h1F, 5'h17, 5'h10, 5'h12, 5'h11, 5'h1F};

    repeat (3) @(negedge clk);
    #1;
    // R1: reset state while held
    check("R1", 32'(curMode), 32'h1F);
    rst_n = 1'b1;
    @(negedge clk); #1;
    checkAll(0, "R1");
    check("R1", 32'(curMode), 32'h1F);

    // R2: system mode load of every register
    for (int i = 0; i < 16; i++) writeReg(i, pat(0, i));
    writeSsr(ssrPat(0));
    written[0] = 1;
    checkAll(0, "R2");

    // R5/R6/R7/R8: each banked mode starts fresh, then gets its own values
    foreach (fwd[k]) begin
      int b;
      b = bankIdx(fwd[k]);
      changeMode(fwd[k], "R10");
      checkAll(b, "R5");
      for (int i = (b == 1) ? 8 : 13; i < 15; i++) writeReg(i, pat(b, i));
      writeSsr(ssrPat(b));
      written[b] = 1;
      checkAll(b, "R6");
    end

    // R6/R7/R8: round trip, every bank's contents intact
    foreach (back[k]) begin
      changeMode(back[k], "R10");
      checkAll(bankIdx(back[k]), "R7");
    end

    // R3: same-mode request in system and in interrupt mode
    changeMode(5'h1F, "R3");
    checkAll(0, "R3");
    changeMode(5'h12, "R10");
    changeMode(5'h12, "R3");
    checkAll(2, "R3");

    // R5: unrecognised encoding uses the unbanked set
    changeMode(5'h05, "R5");
    checkAll(0, "R5");

    // R4: user <-> system swaps nothing
    changeMode(5'h10, "R4");
    checkAll(0, "R4");
    changeMode(5'h1F, "R4");
    checkAll(0, "R4");
    changeMode(5'h10, "R4");

    // R9: write to r13 and saved status in the change cycle
    @(negedge clk);
    modeReq = 1'b1; modeTarget = 5'h13;
    wrEn = 1'b1; wrAddr = 4'd13; wrData = 32'hFACE_0013;
    ssrWrEn = 1'b1; ssrWrData = 32'hFACE_5353;
    @(negedge clk);
    modeReq = 1'b0; wrEn = 1'b0; ssrWrEn = 1'b0;
    rdAddrA = 4'd13; rdAddrB = 4'd14; #1;
    check("R9", rdDataA, 32'hFACE_0013);
    check("R9", rdDataB, pat(3, 14));
    check("R9", ssrRdData, 32'hFACE_5353);
    changeMode(5'h1F, "R10");
    rdAddrA = 4'd13; #1;
    check("R9", rdDataA, pat(0, 13));
    check("R8", ssrRdData, ssrPat(0));
    changeMode(5'h13, "R10");
    rdAddrA = 4'd13; #1;
    check("R9", rdDataA, 32'hFACE_0013);
    check("R9", ssrRdData, 32'hFACE_5353);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule